// File: doc/BRIEF.md
# Vectored Interrupt Controller with Message Output

The block collects up to 64 interrupt request lines and turns each active one into a short message holding an 8-bit vector and an 8-bit route byte. Every line is brought into the clock domain by a two-flop synchronizer. A per-line sense bit and a per-line polarity bit select among four conditions: rising edge, falling edge, active-high level or active-low level. Edge conditions set a sticky pending bit that software drops with a write-one-to-clear bank. Level conditions count as pending for as long as the corrected level stays active.

A pending line is eligible when its mask bit is 0 and its message-enable bit is 1. A scan picks the lowest-numbered eligible line and places its vector and route bytes on a valid/ready output. Once `msg_valid` is high, the message stays fixed until the target takes it with `msg_ready`. Back-pressure therefore only delays delivery and never loses a request: lines that stay pending are offered again later. After an edge line's message is accepted, that line stays quiet until its pending bit is cleared and a new edge arrives.

Software uses a simple 32-bit register port. Writes take effect on the clock edge where `reg_we` is high. Read data appears on `reg_rdata` one cycle after `reg_re`.

Top module: `vic_irq_ctrl`

## Requirements
- R1: After reset both mask words (0x20, 0x24) read 0xFFFFFFFF and every other register reads 0. Word 0x04 reads 0x003F0000, which is the line count minus one in bits 23:16. Word 0x00 reads 0. Unmapped or unaligned offsets read 0, and writes to them are ignored.
- R2: Line n uses bit n%32 of word n/32 in every bank. The bank bases are mask 0x20, message enable 0x40, sense 0x60, clear 0x80, spare storage 0xC0 and 0xE0, and polarity 0x3E0. Route byte n sits at 0x100+n and vector byte n at 0x200+n, with four bytes per word, little-endian. Stored words read back as written.
- R3: The {sense, polarity} bits select the condition: 1,0 is rising edge; 1,1 is falling edge; 0,0 is level high; 0,1 is level low.
- R4: A line whose mask bit is 1 or whose enable bit is 0 produces no message.
- R5: A message carries the vector byte and the route byte stored for the line it represents.
- R6: When several lines are eligible, the lowest-numbered one is sent first.
- R7: While `msg_valid` is high and `msg_ready` is low, `msg_valid`, `msg_vec` and `msg_route` hold their values.
- R8: After its message is accepted, an edge line is not sent again until a clear-bank 1 is written to its bit and a new edge occurs. Clear-bank bits written as 0 have no effect, and the clear bank reads 0.
- R9: A level line is offered again after each acceptance while it stays active, and stops once it goes inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | 64 | Raw interrupt request lines (asynchronous) |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 10 | Byte offset of the 32-bit word accessed |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_re` |
| msg_valid | output | 1 | Message present |
| msg_ready | input | 1 | Target accepts the message |
| msg_vec | output | 8 | Vector byte of the message |
| msg_route | output | 8 | Route byte of the message |

## Verification
The assertions assume that the request lines are quasi-static around the clock edge, that reads are issued one at a time, and that a write and a read never target the mask or enable words in the same cycle that the checker compares. The stimulus changes the lines and the register strobes only on the falling clock edge. It changes polarity only while a line is held at its inactive level, so that no false edge appears. It also drains any message still in flight before it checks for silence. This lets the checker trust its one-cycle-delayed copies of the mask, enable and eligibility vectors.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int WORD_W   = 32;
  // word indices (byte offset / 4) of the register banks
  localparam int WI_ID    = 0;
  localparam int WI_MASK  = 8;
  localparam int WI_MEN   = 16;
  localparam int WI_SENSE = 24;
  localparam int WI_CLR   = 32;
  localparam int WI_SPR0  = 48;
  localparam int WI_SPR1  = 56;
  localparam int WI_ROUTE = 64;
  localparam int WI_VEC   = 128;
  localparam int WI_POL   = 248;
  typedef logic [7:0] byte_t;
endpackage

// File: rtl/vic_sync.sv
module vic_sync #(
  parameter int N = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raw,
  input  logic [N-1:0] pol,
  output logic [N-1:0] lvl,
  output logic [N-1:0] act_edge
);
  logic [N-1:0] s1_q, s2_q, lvl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_q  <= '0;
      s2_q  <= '0;
      lvl_q <= '0;
    end else begin
      s1_q  <= raw;
      s2_q  <= s1_q;
      lvl_q <= lvl;
    end
  end

  // polarity-corrected level; active edge is the 0->1 step of that level
  assign lvl      = s2_q ^ pol;
  assign act_edge = lvl & ~lvl_q;
endmodule

// File: rtl/vic_regs.sv
module vic_regs
  import vic_pkg::*;
#(
  parameter int N  = 64,
  parameter int AW = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic                re,
  input  logic [AW-1:0]       addr,
  input  logic [WORD_W-1:0]   wdata,
  output logic [WORD_W-1:0]   rdata,
  output logic [N-1:0]        mask,
  output logic [N-1:0]        men,
  output logic [N-1:0]        sense,
  output logic [N-1:0]        pol,
  output logic [N-1:0]        clr,
  output logic [N-1:0][7:0]   route,
  output logic [N-1:0][7:0]   vec
);
  localparam int NW = N / WORD_W;
  localparam int NB = WORD_W / 8;

  logic [AW-3:0]       wi;
  logic                aligned;
  logic [N-1:0]        spr0, spr1;
  logic [WORD_W-1:0]   rd_mux;

  assign wi      = addr[AW-1:2];
  assign aligned = (addr[1:0] == 2'b00);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask  <= '1;
      men   <= '0;
      sense <= '0;
      pol   <= '0;
      spr0  <= '0;
      spr1  <= '0;
      route <= '0;
      vec   <= '0;
    end else if (we && aligned) begin
      for (int k = 0; k < NW; k++) begin
        if (int'(wi) == WI_MASK  + k) mask [k*WORD_W +: WORD_W] <= wdata;
        if (int'(wi) == WI_MEN   + k) men  [k*WORD_W +: WORD_W] <= wdata;
        if (int'(wi) == WI_SENSE + k) sense[k*WORD_W +: WORD_W] <= wdata;
        if (int'(wi) == WI_POL   + k) pol  [k*WORD_W +: WORD_W] <= wdata;
        if (int'(wi) == WI_SPR0  + k) spr0 [k*WORD_W +: WORD_W] <= wdata;
        if (int'(wi) == WI_SPR1  + k) spr1 [k*WORD_W +: WORD_W] <= wdata;
      end
      for (int n = 0; n < N; n++) begin
        if (int'(wi) == WI_ROUTE + n/NB) route[n] <= wdata[8*(n%NB) +: 8];
        if (int'(wi) == WI_VEC   + n/NB) vec[n]   <= wdata[8*(n%NB) +: 8];
      end
    end
  end

  // write-one-to-clear pulses, one cycle wide
  always_comb begin
    clr = '0;
    if (we && aligned) begin
      for (int k = 0; k < NW; k++)
        if (int'(wi) == WI_CLR + k) clr[k*WORD_W +: WORD_W] = wdata;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (aligned) begin
      if (int'(wi) == WI_ID + 1) rd_mux[23:16] = 8'(N - 1);
      for (int k = 0; k < NW; k++) begin
        if (int'(wi) == WI_MASK  + k) rd_mux = mask [k*WORD_W +: WORD_W];
        if (int'(wi) == WI_MEN   + k) rd_mux = men  [k*WORD_W +: WORD_W];
        if (int'(wi) == WI_SENSE + k) rd_mux = sense[k*WORD_W +: WORD_W];
        if (int'(wi) == WI_POL   + k) rd_mux = pol  [k*WORD_W +: WORD_W];
        if (int'(wi) == WI_SPR0  + k) rd_mux = spr0 [k*WORD_W +: WORD_W];
        if (int'(wi) == WI_SPR1  + k) rd_mux = spr1 [k*WORD_W +: WORD_W];
      end
      for (int n = 0; n < N; n++) begin
        if (int'(wi) == WI_ROUTE + n/NB) rd_mux[8*(n%NB) +: 8] = route[n];
        if (int'(wi) == WI_VEC   + n/NB) rd_mux[8*(n%NB) +: 8] = vec[n];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)  rdata <= '0;
    else if (re) rdata <= rd_mux;
  end
endmodule

// File: rtl/vic_core.sv
module vic_core #(
  parameter int N  = 64,
  parameter int IW = $clog2(N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      lvl,
  input  logic [N-1:0]      act_edge,
  input  logic [N-1:0]      sense,
  input  logic [N-1:0]      mask,
  input  logic [N-1:0]      men,
  input  logic [N-1:0]      clr,
  input  logic [N-1:0][7:0] route,
  input  logic [N-1:0][7:0] vec,
  input  logic              msg_ready,
  output logic              msg_valid,
  output logic [7:0]        msg_vec,
  output logic [7:0]        msg_route,
  output logic [IW-1:0]     msg_idx,
  output logic [N-1:0]      elig
);
  logic [N-1:0]  latch_q, sent_q, pend, acc_set;
  logic          found;
  logic [IW-1:0] pick;

  always_comb begin
    acc_set = '0;
    if (msg_valid && msg_ready) acc_set[msg_idx] = 1'b1;
  end

  // a new edge wins over a clear in the same cycle
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latch_q <= '0;
      sent_q  <= '0;
    end else begin
      latch_q <= (latch_q & ~clr) | (act_edge & sense);
      sent_q  <= (sent_q & ~clr) | (acc_set & sense);
    end
  end

  assign pend = (sense & latch_q & ~sent_q) | (~sense & lvl);
  assign elig = pend & ~mask & men;

  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (elig[i]) begin
        found = 1'b1;
        pick  = IW'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msg_valid <= 1'b0;
      msg_idx   <= '0;
      msg_vec   <= '0;
      msg_route <= '0;
    end else if (msg_valid) begin
      if (msg_ready) msg_valid <= 1'b0;
    end else if (found) begin
      msg_valid <= 1'b1;
      msg_idx   <= pick;
      msg_vec   <= vec[pick];
      msg_route <= route[pick];
    end
  end
endmodule

// File: rtl/vic_irq_ctrl.sv
module vic_irq_ctrl #(
  parameter int NUM_IN = 64,
  parameter int AW     = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_IN-1:0] irq_in,
  input  logic              reg_we,
  input  logic              reg_re,
  input  logic [AW-1:0]     reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              msg_valid,
  input  logic              msg_ready,
  output logic [7:0]        msg_vec,
  output logic [7:0]        msg_route
);
  localparam int IW = $clog2(NUM_IN);

  logic [NUM_IN-1:0]      mask_r, men_r, sense_r, pol_r, clr_p;
  logic [NUM_IN-1:0]      lvl, act_edge, elig;
  logic [NUM_IN-1:0][7:0] route_r, vec_r;
  logic [IW-1:0]          msg_idx;

  vic_sync #(.N(NUM_IN)) sync_i (
    .clk(clk), .rst_n(rst_n), .raw(irq_in), .pol(pol_r),
    .lvl(lvl), .act_edge(act_edge)
  );

  vic_regs #(.N(NUM_IN), .AW(AW)) regs_i (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .re(reg_re), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .mask(mask_r), .men(men_r),
    .sense(sense_r), .pol(pol_r), .clr(clr_p), .route(route_r), .vec(vec_r)
  );

  vic_core #(.N(NUM_IN), .IW(IW)) core_i (
    .clk(clk), .rst_n(rst_n), .lvl(lvl), .act_edge(act_edge),
    .sense(sense_r), .mask(mask_r), .men(men_r), .clr(clr_p),
    .route(route_r), .vec(vec_r), .msg_ready(msg_ready),
    .msg_valid(msg_valid), .msg_vec(msg_vec), .msg_route(msg_route),
    .msg_idx(msg_idx), .elig(elig)
  );
endmodule

// File: rtl/vic_chk.sv
module vic_chk #(
  parameter int N  = 64,
  parameter int AW = 10,
  parameter int IW = $clog2(N)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          msg_valid,
  input logic          msg_ready,
  input logic [7:0]    msg_vec,
  input logic [7:0]    msg_route,
  input logic [IW-1:0] msg_idx,
  input logic [N-1:0]  elig,
  input logic [N-1:0]  mask,
  input logic [N-1:0]  men,
  input logic          reg_re,
  input logic [AW-1:0] reg_addr,
  input logic [31:0]   reg_rdata
);
  localparam logic [N-1:0] ONE = N'(1);
  logic [N-1:0] elig_q, mask_q, men_q;

  always_ff @(posedge clk) begin
    elig_q <= elig;
    mask_q <= mask;
    men_q  <= men;
  end

  // R7: message held under back-pressure
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_vec) && $stable(msg_route));

  // R4: a new message only for an unmasked, enabled line
  p_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msg_valid) |-> !mask_q[msg_idx] && men_q[msg_idx]);

  // R6: no lower-numbered line was eligible when the pick was made
  p_lowest_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msg_valid) |-> (elig_q & ((ONE << msg_idx) - ONE)) == '0);

  // R6: the picked line itself was eligible
  p_picked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msg_valid) |-> elig_q[msg_idx]);

  // R1: identification word
  p_id_r1: assert property (@(posedge clk) disable iff (!rst_n)
    reg_re && reg_addr == AW'(4) |=> reg_rdata == {8'h00, 8'(N - 1), 16'h0000});
endmodule

bind vic_irq_ctrl vic_chk #(.N(NUM_IN), .AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_ready(msg_ready),
  .msg_vec(msg_vec), .msg_route(msg_route), .msg_idx(msg_idx), .elig(elig),
  .mask(mask_r), .men(men_r), .reg_re(reg_re), .reg_addr(reg_addr),
  .reg_rdata(reg_rdata)
);

// File: tb/vic_irq_ctrl_tb_top.sv
module vic_irq_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] irq_in = '0;
  logic        reg_we = 1'b0, reg_re = 1'b0, msg_ready = 1'b0;
  logic [9:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        msg_valid;
  logic [7:0]  msg_vec, msg_route;
  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  vic_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_we(reg_we), .reg_re(reg_re),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_vec(msg_vec),
    .msg_route(msg_route)
  );

  // {line[7:0], sense, pol, vector[7:0], route[7:0]}
  localparam logic [25:0] TBL [6] = '{
    {8'd0,  1'b1, 1'b0, 8'hA0, 8'h01},
    {8'd37, 1'b1, 1'b1, 8'hB5, 8'h02},
    {8'd31, 1'b0, 1'b0, 8'hC1, 8'h03},
    {8'd63, 1'b0, 1'b1, 8'hD3, 8'h04},
    {8'd32, 1'b1, 1'b0, 8'hE2, 8'h05},
    {8'd5,  1'b0, 1'b1, 8'hF7, 8'h06}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk); reg_re = 1'b1; reg_addr = a;
    @(negedge clk); reg_re = 1'b0; d = reg_rdata;
  endtask

  // wait for a message, optionally accept it
  task automatic get_msg(input bit accept, output bit got, output logic [7:0] v, output logic [7:0] r);
    got = 1'b0; v = '0; r = '0;
    for (int i = 0; i < 20 && !got; i++) begin
      @(negedge clk);
      if (msg_valid) begin got = 1'b1; v = msg_vec; r = msg_route; end
    end
    if (got && accept) begin
      msg_ready = 1'b1; @(negedge clk); msg_ready = 1'b0;
    end
  endtask

  task automatic quiet(input int cyc, output bit seen);
    seen = 1'b0;
    for (int i = 0; i < cyc; i++) begin @(negedge clk); if (msg_valid) seen = 1'b1; end
  endtask

  task automatic drain();
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (msg_valid) begin msg_ready = 1'b1; @(negedge clk); msg_ready = 1'b0; end
    end
  endtask

  task automatic cfg(input int n, input bit s, input bit p, input logic [7:0] v,
                     input logic [7:0] r, input bit en);
    logic [9:0] wo; logic [31:0] bit_m; int ln;
    wo = 10'(4 * (n / 32)); bit_m = 32'd1 << (n % 32); ln = n % 4;
    irq_in[n] = p;
    repeat (4) @(negedge clk);
    wr(10'h3E0 + wo, p ? bit_m : 32'h0);
    wr(10'h060 + wo, s ? bit_m : 32'h0);
    wr(10'h100 + 10'(n & ~3), 32'(r) << (8 * ln));
    wr(10'h200 + 10'(n & ~3), 32'(v) << (8 * ln));
    wr(10'h080, '1); wr(10'h084, '1);
    wr(10'h040 + wo, en ? bit_m : 32'h0);
    wr(10'h020 + wo, ~bit_m);
  endtask

  task automatic cleanup();
    wr(10'h020, '1); wr(10'h024, '1);
    wr(10'h060, '0); wr(10'h064, '0);
    irq_in = '0;
    repeat (4) @(negedge clk);
    wr(10'h3E0, '0); wr(10'h3E4, '0);
    wr(10'h040, '0); wr(10'h044, '0);
    wr(10'h080, '1); wr(10'h084, '1);
    drain();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d; bit got, seen; logic [7:0] v, r;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset values
    rd(10'h020, d); chk(d == 32'hFFFFFFFF, "R1 mask0", d, 32'hFFFFFFFF);
    rd(10'h024, d); chk(d == 32'hFFFFFFFF, "R1 mask1", d, 32'hFFFFFFFF);
    rd(10'h004, d); chk(d == 32'h003F0000, "R1 id", d, 32'h003F0000);
    rd(10'h000, d); chk(d == 32'h0, "R1 id low", d, 0);
    rd(10'h060, d); chk(d == 32'h0, "R1 sense", d, 0);
    rd(10'h23C, d); chk(d == 32'h0, "R1 vec", d, 0);
    wr(10'h300, 32'h12345678);
    rd(10'h300, d); chk(d == 32'h0, "R1 unmapped", d, 0);
    wr(10'h3E2, 32'hFFFFFFFF);
    rd(10'h3E0, d); chk(d == 32'h0, "R1 unaligned write ignored", d, 0);

    // R2: layout and readback
    wr(10'h3E4, 32'hA5A50F0F);
    rd(10'h3E4, d); chk(d == 32'hA5A50F0F, "R2 pol1", d, 32'hA5A50F0F);
    wr(10'h3E4, 32'h0);
    wr(10'h104, 32'h44332211);
    rd(10'h104, d); chk(d == 32'h44332211, "R2 route word", d, 32'h44332211);
    wr(10'hC4, 32'h5A5A0001);
    rd(10'hC4, d); chk(d == 32'h5A5A0001, "R2 spare", d, 32'h5A5A0001);
    // R8: clear bank reads zero
    wr(10'h080, 32'hFFFFFFFF);
    rd(10'h080, d); chk(d == 32'h0, "R8 clear reads 0", d, 0);

    // table: R3 R5 R8 R9
    for (int e = 0; e < 6; e++) begin
      int n; bit s, p; logic [7:0] ev, er;
      {n[7:0], s, p, ev, er} = TBL[e]; n = int'(TBL[e][25:18]);
      cfg(n, s, p, ev, er, 1'b1);
      quiet(6, seen); chk(!seen, "R3 inactive quiet", 32'(seen), 0);
      irq_in[n] = ~p;
      get_msg(1'b1, got, v, r);
      chk(got && v == ev && r == er, "R3 R5 message", {got, 7'h0, 8'h0, v, r}, {8'h80, 8'h0, ev, er});
      if (s) begin
        quiet(8, seen); chk(!seen, "R8 no resend", 32'(seen), 0);
      end else begin
        get_msg(1'b1, got, v, r); chk(got && v == ev, "R9 level resend", 32'(v), 32'(ev));
        irq_in[n] = p; drain();
        quiet(6, seen); chk(!seen, "R9 level stops", 32'(seen), 0);
      end
      cleanup();
    end

    // R4: mask and enable gating (line 10, level high)
    cfg(10, 1'b0, 1'b0, 8'h1A, 8'h07, 1'b0);
    wr(10'h020, 32'hFFFFFFFF); // masked and disabled
    irq_in[10] = 1'b1;
    quiet(8, seen); chk(!seen, "R4 masked", 32'(seen), 0);
    wr(10'h020, ~(32'd1 << 10));
    quiet(8, seen); chk(!seen, "R4 disabled", 32'(seen), 0);
    wr(10'h040, 32'd1 << 10);
    get_msg(1'b1, got, v, r); chk(got && v == 8'h1A, "R4 enabled", 32'(v), 32'h1A);
    cleanup();

    // R6 R7: lowest first, hold under back-pressure
    cfg(40, 1'b0, 1'b0, 8'h40, 8'h0A, 1'b1);
    cfg(12, 1'b0, 1'b0, 8'h12, 8'h0B, 1'b1);
    wr(10'h020, ~(32'd1 << 12)); wr(10'h024, ~(32'd1 << 8));
    wr(10'h040, 32'd1 << 12);    wr(10'h044, 32'd1 << 8);
    @(negedge clk); irq_in[12] = 1'b1; irq_in[40] = 1'b1;
    get_msg(1'b0, got, v, r); chk(got && v == 8'h12, "R6 lowest first", 32'(v), 32'h12);
    irq_in[12] = 1'b0;
    repeat (5) @(negedge clk);
    chk(msg_valid && msg_vec == 8'h12 && msg_route == 8'h0B, "R7 held",
        {msg_valid, 7'h0, 8'h0, msg_vec, msg_route}, 32'h8000120B);
    msg_ready = 1'b1; @(negedge clk); msg_ready = 1'b0;
    get_msg(1'b1, got, v, r); chk(got && v == 8'h40 && r == 8'h0A, "R6 next line", 32'(v), 32'h40);
    cleanup();

    // R8: clear semantics on edge line 3
    cfg(3, 1'b1, 1'b0, 8'h33, 8'h0C, 1'b1);
    irq_in[3] = 1'b1;
    get_msg(1'b1, got, v, r); chk(got && v == 8'h33, "R8 first edge", 32'(v), 32'h33);
    wr(10'h080, ~(32'd1 << 3));
    irq_in[3] = 1'b0; repeat (3) @(negedge clk); irq_in[3] = 1'b1;
    quiet(8, seen); chk(!seen, "R8 zero bits no effect", 32'(seen), 0);
    wr(10'h080, 32'd1 << 3);
    quiet(8, seen); chk(!seen, "R8 clear drops pending", 32'(seen), 0);
    irq_in[3] = 1'b0; repeat (3) @(negedge clk); irq_in[3] = 1'b1;
    get_msg(1'b1, got, v, r); chk(got && v == 8'h33, "R8 new edge after clear", 32'(v), 32'h33);
    cleanup();

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule